// File: doc/BRIEF.md
# Physical Memory Protection Region Checker

This block holds a small, fixed set of protection regions and decides every cycle whether a data access may read or write, and whether an instruction fetch may execute. Each region has an 8-bit configuration byte (permissions, matching mode, lock) and a 32-bit address register that holds a byte address shifted right by two. A region can be disabled or can match by top-of-range (bounded below by the preceding region's address register), by one aligned 4-byte word, or by an aligned power-of-two block whose size is encoded in the trailing ones of its address register.

Software-visible state is loaded through a one-cycle register-write port. A write selects either a packed configuration word (four regions per word) or one region's address register. Locked regions refuse writes until reset, and a locked top-of-range region also protects the address register below it, which is its lower bound. The data address and the fetch address are each compared against every region in the same cycle. The lowest-numbered matching region alone decides. Machine mode is exempt from unlocked regions and gets full access where no region matches, while lower privileges are denied.

Top module: `pmp_checker`

## Requirements
- R1: A configuration write with index c stores bits [8j+7:8j] of the data in region 4c+j. In each byte, bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 select the mode and bit 7 is the lock. Bits 6:5 are dropped and have no effect.
- R2: After reset every region is disabled (mode 0) and unlocked. Machine mode then gets full access and a lower privilege gets none.
- R3: When no region matches, all three allow outputs equal the machine-mode input.
- R4: In mode 1 (top-of-range), region i matches byte addresses A with prev*4 <= A < own*4. Here prev is region i-1's address register, whatever that region's mode, and zero for region 0.
- R5: In mode 2, a region matches only the 4-byte word whose address shifted right by two equals its address register.
- R6: In mode 3, k trailing ones in the address register give a 2^(k+3)-byte region aligned to its size. Zero trailing ones give 8 bytes.
- R7: When several regions match, only the lowest-numbered one supplies the permissions.
- R8: In machine mode, a matching unlocked region grants everything, and a matching locked region applies its R/W/X bits.
- R9: A set lock bit makes writes to that region's configuration byte and address register have no effect until reset. Unlocked bytes in the same configuration word are still written.
- R10: A write to region i's address register is ignored while region i+1 is locked and in mode 1.
- R11: The fetch address is checked against the X bit independently of the data address, which is checked against R and W, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_cfg | input | 1 | 1: configuration word write, 0: address register write |
| wr_idx | input | 3 | Configuration word index or region index |
| wr_data | input | 32 | Write data |
| machine_mode | input | 1 | Access is made at machine privilege |
| d_addr | input | 32 | Data access byte address |
| i_addr | input | 32 | Instruction fetch byte address |
| d_allow_r | output | 1 | Data read allowed |
| d_allow_w | output | 1 | Data write allowed |
| i_allow_x | output | 1 | Fetch execute allowed |

## Verification
A fixed region map overlays a four-byte word, a 32-byte block, a top-of-range span and a 64 KiB block over low memory, and adds a locked 8-byte block above it. Table probes sit on the first and last word inside each region and on the word just outside it, which separates off-by-one bound errors from size-decoding errors. Probes in the overlapping areas expose a wrong priority order. The same addresses probed in both privilege modes separate the lock rule from the no-match default. Directed sequences then rewrite locked and unlocked bytes in one word, make region 0 top-of-range, and chain a locked top-of-range region onto its neighbour. A final reset shows that the locks are released.

// File: rtl/pmp_chk_pkg.sv
// Shared types for the protection checker: configuration byte layout,
// matching-mode encoding and permission triple.
package pmp_chk_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    // Byte layout, MSB first: lock, two zero bits, mode, x, w, r
    typedef struct packed {
        logic        lock;
        logic [1:0]  zero;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } region_cfg_t;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    localparam logic [7:0] CFG_KEEP  = 8'h9F;
    localparam int         PER_WORD  = 4;
endpackage

// File: rtl/pmp_cfg_store.sv
// Region register file. Holds one configuration byte and one address
// register per region and applies register-port writes subject to the lock
// rules. Assumes NREG is a multiple of PER_WORD and AW is at least 32.
module pmp_cfg_store
    import pmp_chk_pkg::*;
#(
    parameter  int NREG  = 8,
    parameter  int AW    = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cfg,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [AW-1:0]    wr_data,
    output region_cfg_t      cfg_o  [NREG],
    output logic [AW-1:0]    addr_o [NREG]
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam int WORD = k / PER_WORD;
        localparam int LANE = k % PER_WORD;

        region_cfg_t   cfg_r;
        logic [AW-1:0] addr_r;
        logic          cfg_sel;
        logic          addr_sel;
        logic          guard_next;

        assign cfg_sel  = wr_en && wr_cfg  && (int'(wr_idx) == WORD);
        assign addr_sel = wr_en && !wr_cfg && (int'(wr_idx) == k);

        if (k < NREG - 1) begin : g_nxt
            // A locked top-of-range neighbour freezes this lower bound
            assign guard_next = cfg_o[k+1].lock && (cfg_o[k+1].mode == MODE_TOR);
        end else begin : g_last
            assign guard_next = 1'b0;
        end

        // Register update: lock blocks both fields, neighbour guard blocks address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r  <= '0;
                addr_r <= '0;
            end else begin
                if (cfg_sel && !cfg_r.lock)
                    cfg_r <= region_cfg_t'(wr_data[8*LANE +: 8] & CFG_KEEP);
                if (addr_sel && !cfg_r.lock && !guard_next)
                    addr_r <= wr_data;
            end
        end

        assign cfg_o[k]  = cfg_r;
        assign addr_o[k] = addr_r;

        // R9
        lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_r.lock |=> ($stable(cfg_r) && $stable(addr_r)))
            else $error("locked region %0d changed", k);

        // R10
        tor_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
            guard_next |=> $stable(addr_r))
            else $error("guarded address %0d changed", k);
    end
endmodule

// File: rtl/pmp_region_match.sv
// Address comparator bank. For one byte address, computes a per-region hit
// from each region's mode and address register. Address registers hold
// byte address bits [AW+1:2]; the access address is extended with zeros.
module pmp_region_match
    import pmp_chk_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input  region_cfg_t     cfg_i  [NREG],
    input  logic [AW-1:0]   addr_i [NREG],
    input  logic [AW-1:0]   acc_addr,
    output logic [NREG-1:0] hit_o
);
    logic [AW-1:0] word;
    assign word = {2'b00, acc_addr[AW-1:2]};

    for (genvar k = 0; k < NREG; k++) begin : g_cmp
        logic [AW-1:0] lo;
        logic [AW-1:0] ones;
        logic [AW-1:0] care;
        logic          m;

        if (k == 0) begin : g_zero
            assign lo = '0;
        end else begin : g_prev
            assign lo = addr_i[k-1];
        end

        // Trailing ones of the address register, plus one more ignored bit
        assign ones = addr_i[k] & ~(addr_i[k] + 1'b1);
        assign care = ~{ones[AW-2:0], 1'b1};

        // Mode-dependent comparison
        always_comb begin
            unique case (cfg_i[k].mode)
                MODE_OFF:   m = 1'b0;
                MODE_TOR:   m = (word >= lo) && (word < addr_i[k]);
                MODE_NA4:   m = (word == addr_i[k]);
                MODE_NAPOT: m = (((word ^ addr_i[k]) & care) == '0);
                default:    m = 1'b0;
            endcase
        end

        assign hit_o[k] = m;
    end
endmodule

// File: rtl/pmp_perm_select.sv
// Priority resolver. Picks the lowest-numbered hit and turns its
// configuration and the privilege level into allow flags.
module pmp_perm_select
    import pmp_chk_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [NREG-1:0] hit_i,
    input  region_cfg_t     cfg_i [NREG],
    input  logic            mmode,
    output perm_t           allow_o
);
    region_cfg_t picked;
    logic        any_hit;
    logic        enforce;

    // Scan downward so the lowest index overwrites last
    always_comb begin
        picked = '0;
        for (int k = NREG - 1; k >= 0; k--)
            if (hit_i[k]) picked = cfg_i[k];
    end

    assign any_hit = |hit_i;
    assign enforce = picked.lock || !mmode;

    // Final decision: default by privilege, else locked/lower-privilege rules
    always_comb begin
        if (!any_hit)
            allow_o = '{r: mmode, w: mmode, x: mmode};
        else if (enforce)
            allow_o = '{r: picked.r, w: picked.w, x: picked.x};
        else
            allow_o = '{r: 1'b1, w: 1'b1, x: 1'b1};
    end
endmodule

// File: rtl/pmp_checker.sv
// Top level of the protection checker. Shares one region register file
// between a data-side and a fetch-side comparator bank; each bank feeds its
// own priority resolver. Outputs are combinational from the address inputs.
module pmp_checker
    import pmp_chk_pkg::*;
#(
    parameter  int NREG  = 8,
    parameter  int AW    = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cfg,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [AW-1:0]    wr_data,
    input  logic             machine_mode,
    input  logic [AW-1:0]    d_addr,
    input  logic [AW-1:0]    i_addr,
    output logic             d_allow_r,
    output logic             d_allow_w,
    output logic             i_allow_x
);
    region_cfg_t     cfg  [NREG];
    logic [AW-1:0]   areg [NREG];
    logic [NREG-1:0] d_hit;
    logic [NREG-1:0] i_hit;
    perm_t           d_perm;
    perm_t           i_perm;

    pmp_cfg_store #(.NREG(NREG), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg),
        .wr_idx(wr_idx), .wr_data(wr_data), .cfg_o(cfg), .addr_o(areg)
    );

    pmp_region_match #(.NREG(NREG), .AW(AW)) u_dmatch (
        .cfg_i(cfg), .addr_i(areg), .acc_addr(d_addr), .hit_o(d_hit)
    );

    pmp_region_match #(.NREG(NREG), .AW(AW)) u_imatch (
        .cfg_i(cfg), .addr_i(areg), .acc_addr(i_addr), .hit_o(i_hit)
    );

    pmp_perm_select #(.NREG(NREG)) u_dsel (
        .hit_i(d_hit), .cfg_i(cfg), .mmode(machine_mode), .allow_o(d_perm)
    );

    pmp_perm_select #(.NREG(NREG)) u_isel (
        .hit_i(i_hit), .cfg_i(cfg), .mmode(machine_mode), .allow_o(i_perm)
    );

    assign d_allow_r = d_perm.r;
    assign d_allow_w = d_perm.w;
    assign i_allow_x = i_perm.x;

    // R3
    data_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit == '0) |-> (d_allow_r == machine_mode && d_allow_w == machine_mode))
        else $error("data no-match default wrong");

    // R3
    fetch_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_hit == '0) |-> (i_allow_x == machine_mode))
        else $error("fetch no-match default wrong");

    // R7
    data_first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit[0] && (cfg[0].lock || !machine_mode))
            |-> (d_allow_r == cfg[0].r && d_allow_w == cfg[0].w))
        else $error("region 0 did not win data check");

    // R11
    fetch_first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_hit[0] && (cfg[0].lock || !machine_mode)) |-> (i_allow_x == cfg[0].x))
        else $error("region 0 did not win fetch check");
endmodule

// File: tb/tb_pmp_checker.sv
// Table-driven bench followed by directed lock, chaining and reset tests.
module tb_pmp_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_cfg = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        machine_mode = 1'b0;
    logic [31:0] d_addr = '0;
    logic [31:0] i_addr = '0;
    logic        d_allow_r, d_allow_w, i_allow_x;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pmp_checker dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg),
        .wr_idx(wr_idx), .wr_data(wr_data), .machine_mode(machine_mode),
        .d_addr(d_addr), .i_addr(i_addr), .d_allow_r(d_allow_r),
        .d_allow_w(d_allow_w), .i_allow_x(i_allow_x)
    );

    // Vector: {machine_mode, d_addr, i_addr, expected {r,w,x}}
    localparam int NV = 15;
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 32'h0000_1000, 32'h0000_1000, 3'b100},
        {1'b0, 32'h0000_1004, 32'h0000_1004, 3'b111},
        {1'b0, 32'h0000_2000, 32'h0000_201C, 3'b110},
        {1'b0, 32'h0000_2020, 32'h0000_2020, 3'b111},
        {1'b0, 32'h0000_4000, 32'h0000_4000, 3'b001},
        {1'b0, 32'h0000_4FFC, 32'h0000_4FFC, 3'b001},
        {1'b0, 32'h0000_5000, 32'h0000_5000, 3'b111},
        {1'b0, 32'h0000_3FFC, 32'h0000_3FFC, 3'b111},
        {1'b0, 32'h0001_0000, 32'h0001_0004, 3'b100},
        {1'b0, 32'h0001_0008, 32'h0001_0008, 3'b000},
        {1'b1, 32'h0001_0008, 32'h0001_0008, 3'b111},
        {1'b1, 32'h0000_1000, 32'h0000_1000, 3'b111},
        {1'b1, 32'h0001_0000, 32'h0001_0000, 3'b100},
        {1'b0, 32'h0000_FFFC, 32'h0000_FFF0, 3'b111},
        {1'b0, 32'h0000_1000, 32'h0000_4000, 3'b101}
    };
    string vtag [NV] = '{"R5", "R5", "R6", "R6", "R4", "R4", "R4", "R7",
                         "R6", "R3", "R3", "R8", "R8", "R7", "R11"};

    task automatic wreg(input logic is_cfg, input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_cfg = is_cfg; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input string tag, input logic m, input logic [31:0] da,
                         input logic [31:0] ia, input logic [2:0] exp);
        logic [2:0] got;
        @(negedge clk);
        machine_mode = m; d_addr = da; i_addr = ia;
        #1;
        got = {d_allow_r, d_allow_w, i_allow_x};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s m=%0b d=%h i=%h rwx got %b expected %b", tag, m, da, ia, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        probe("R2", 1'b0, 32'h0, 32'h0, 3'b000);
        probe("R2", 1'b1, 32'h0, 32'h0, 3'b111);

        // Region map (R1 packing): address registers then configuration words
        wreg(1'b0, 3'd0, 32'h0000_0400);
        wreg(1'b0, 3'd1, 32'h0000_0803);
        wreg(1'b0, 3'd2, 32'h0000_1000);
        wreg(1'b0, 3'd3, 32'h0000_1400);
        wreg(1'b0, 3'd4, 32'h0000_1FFF);
        wreg(1'b0, 3'd5, 32'h0000_4000);
        wreg(1'b1, 3'd0, 32'h0C00_1B11);
        wreg(1'b1, 3'd1, 32'h0000_991F);

        for (int v = 0; v < NV; v++)
            probe(vtag[v], VEC[v][67], VEC[v][66:35], VEC[v][34:3], VEC[v][2:0]);

        // R9: clearing the word keeps locked region 5, drops unlocked region 4
        wreg(1'b1, 3'd1, 32'h0000_0000);
        probe("R9", 1'b0, 32'h0001_0000, 32'h0001_0000, 3'b100);
        probe("R9", 1'b0, 32'h0000_8000, 32'h0000_8000, 3'b000);
        // R9: address write to locked region is ignored
        wreg(1'b0, 3'd5, 32'h0000_0000);
        probe("R9", 1'b0, 32'h0001_0004, 32'h0001_0004, 3'b100);
        probe("R9", 1'b0, 32'h0000_0004, 32'h0000_0004, 3'b000);

        // R4 and R1: region 0 top-of-range with the zero bits set in its byte
        wreg(1'b1, 3'd0, 32'h0C00_1B69);
        wreg(1'b0, 3'd0, 32'h0000_0100);
        probe("R4", 1'b0, 32'h0000_0000, 32'h0000_0000, 3'b100);
        probe("R1", 1'b0, 32'h0000_03FC, 32'h0000_03FC, 3'b100);
        probe("R4", 1'b0, 32'h0000_0400, 32'h0000_0400, 3'b000);

        // R10: locked top-of-range region 7 guards region 6's address
        wreg(1'b0, 3'd6, 32'h0000_3000);
        wreg(1'b0, 3'd7, 32'h0000_3100);
        wreg(1'b1, 3'd1, 32'h8F00_0000);
        wreg(1'b0, 3'd6, 32'h0000_0000);
        probe("R10", 1'b0, 32'h0000_BFFC, 32'h0000_BFFC, 3'b000);
        probe("R10", 1'b0, 32'h0000_C000, 32'h0000_C000, 3'b111);
        probe("R10", 1'b0, 32'h0000_C3FC, 32'h0000_C3FC, 3'b111);
        probe("R4", 1'b0, 32'h0000_C400, 32'h0000_C400, 3'b000);

        // R2: reset clears locks and regions
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        probe("R2", 1'b0, 32'h0001_0000, 32'h0001_0000, 3'b000);
        probe("R2", 1'b1, 32'h0001_0000, 32'h0001_0000, 3'b111);
        // R9: after reset the former locked region accepts writes again
        wreg(1'b0, 3'd5, 32'h0000_4000);
        wreg(1'b1, 3'd1, 32'h0000_1900);
        probe("R9", 1'b0, 32'h0001_0000, 32'h0001_0000, 3'b100);

        finish_run();
    end
endmodule